// File: doc/BRIEF.md
# Two-Wire Memory Slave Interface

This block is the bus-facing front end of a 2048-byte serial memory. It runs on a fast system clock and oversamples the two bus wires, clock line `scl_i` and data line `sda_i`. Both wires pass through two-flop synchronisers, and edges are found on the synchronised copies. The block recognises start and stop conditions and shifts bytes in MSB first. It answers with an acknowledge by asserting `sda_oe`, which the pad turns into an open-drain pull-down. It shifts read data out through the same enable.

The first byte after a start is the slave byte. Its bits, from MSB down, are a type bit that must be 1, then select bits S2, S1 and S0, then address bits A10..A8, then R/W (1 = read). The block matches S2 against `sel_i[2]` and S0 against `sel_i[0]`. It matches S1 against the inverse of `sel_i[1]`. On a write, the next byte supplies address bits A7..A0 and each later byte is written through a one-cycle `mem_we` pulse. On a read, a `mem_re` pulse fetches a byte, and the memory returns `mem_rdata` on the following cycle. When the internal write cycle of a neighbouring block is running, `busy_i` is high and the block refuses its address. Write commit timing and protection decisions are left to neighbouring blocks.

The state machine has these states:
- `ST_IDLE`: waits for a start.
- `ST_DEV`: shifts in the slave byte.
- `ST_DEV_ACK`: acknowledges the slave byte.
- `ST_WADDR`: shifts in the word address.
- `ST_WADDR_ACK`: acknowledges the word address.
- `ST_WDATA`: shifts in a write byte.
- `ST_WDATA_ACK`: acknowledges a write byte.
- `ST_RD_FETCH`: raises `mem_re`.
- `ST_RD_LOAD`: captures `mem_rdata`.
- `ST_RDATA`: shifts the byte out.
- `ST_RD_ACK`: samples the master's answer.
- `ST_RD_NEXT`: waits for the clock to fall before the next fetch.

The transitions are:
- A start moves any state to `ST_DEV`.
- A stop moves any state to `ST_IDLE`.
- From `ST_DEV`, the falling edge after eight bits goes to `ST_DEV_ACK` on a match while not busy, and to `ST_IDLE` otherwise.
- From `ST_DEV_ACK`, a falling edge goes to `ST_RD_FETCH` for a read and to `ST_WADDR` for a write.
- From `ST_WADDR`, the falling edge after eight bits goes to `ST_WADDR_ACK`, and a falling edge there goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate on the falling edge after each byte.
- `ST_RD_FETCH` goes to `ST_RD_LOAD`, and `ST_RD_LOAD` goes to `ST_RDATA`, one cycle each.
- From `ST_RDATA`, the eighth falling edge goes to `ST_RD_ACK`.
- In `ST_RD_ACK`, a rising clock with data low goes to `ST_RD_NEXT`, and a rising clock with data high goes to `ST_IDLE`.
- From `ST_RD_NEXT`, a falling edge goes to `ST_RD_FETCH`.

Top module: `twowire_mem_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start in any state abandons the current transfer and begins matching a new slave byte. A stop returns the block to idle with no write issued.
- R2: The block acknowledges a slave byte only when bit 7 is 1, bit 6 equals `sel_i[2]`, bit 5 equals the inverse of `sel_i[1]`, and bit 4 equals `sel_i[0]`. Otherwise it leaves SDA released.
- R3: While `busy_i` is high, a matching slave byte gets no acknowledge, and the transfer that follows issues no memory write.
- R4: In a write, bits 3..1 of the slave byte form address bits 10..8 and the next byte forms bits 7..0. Each following data byte is acknowledged and issues one `mem_we` pulse carrying that address and byte.
- R5: After each written byte, only address bits 4..0 increment, wrapping within the 32-byte page. Bits 10..5 are kept.
- R6: In a read, address bits 10..8 come from the read slave byte and bits 7..0 keep the last value set. Each byte is fetched with one `mem_re` pulse and sent MSB first. `mem_we` and `mem_re` are never high together.
- R7: When the master acknowledges a read byte, the full 11-bit address increments, wrapping from 7FFh to 000h, and the next byte follows.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start.
- R9: During reset `sda_oe`, `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| sel_i | input | 3 | Device select pins S2..S0 |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_addr | output | 11 | Memory byte address |
| mem_we | output | 1 | One-cycle write request |
| mem_wdata | output | 8 | Write data |
| mem_re | output | 1 | One-cycle read request |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |

## Verification
The bench sweeps every upper nibble of the slave byte against one pin setting, and then every pin setting with both polarities of S1. A design that matched S1 without inversion would acknowledge exactly the wrong half of these cases. Page writes across the 1Fh boundary and reads across 7FFh catch a carry into the wrong bits: a wrong page write would land in the next page, and a wrong read would return data from the wrong end of memory. A restart halfway through a word address must leave a single write at the address of the second transfer, so a design that kept the partial bit count would store at a corrupted address. After a read that the master does not acknowledge, the bench keeps clocking SCL and would see any stray drive.

// File: rtl/twm_pkg.sv
package twm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_FETCH,
        ST_RD_LOAD,
        ST_RDATA,
        ST_RD_ACK,
        ST_RD_NEXT
    } twm_state_e;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '1;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/twm_bus_events.sv
module twm_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twm_match.sv
module twm_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] slave_byte,
    input  logic [2:0]        sel,
    output logic              hit
);
    localparam int TOP = DATA_W - 1;

    assign hit = slave_byte[TOP]
               & (slave_byte[TOP-1] == sel[2])
               & (slave_byte[TOP-2] == ~sel[1])
               & (slave_byte[TOP-3] == sel[0]);
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
    import twm_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int HI_W        = 3,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        sel_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int LO_W  = ADDR_W - HI_W;

    twm_state_e state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic              rw;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, hit;
    logic              full;

    twm_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    twm_bus_events ev_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twm_match #(.DATA_W(DATA_W)) match_i (
        .slave_byte(shreg), .sel(sel_i), .hit(hit)
    );

    assign full = (cnt == CNT_W'(DATA_W));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_DEV;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_DEV:       if (scl_fall && full) state_nx = (hit && !busy_i) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_nx = rw ? ST_RD_FETCH : ST_WADDR;
                ST_WADDR:     if (scl_fall && full) state_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && full) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RD_FETCH:  state_nx = ST_RD_LOAD;
                ST_RD_LOAD:   state_nx = ST_RDATA;
                ST_RDATA:     if (scl_fall && cnt == CNT_W'(DATA_W - 1)) state_nx = ST_RD_ACK;
                ST_RD_ACK:    if (scl_rise) state_nx = sda_s ? ST_IDLE : ST_RD_NEXT;
                ST_RD_NEXT:   if (scl_fall) state_nx = ST_RD_FETCH;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath: shift register, bit count, address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            addr  <= '0;
            rw    <= 1'b0;
        end else if (start_det) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && !full) begin
                        shreg <= {shreg[DATA_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end
                    if (scl_fall && full) begin
                        if (state == ST_DEV && hit && !busy_i) begin
                            addr[ADDR_W-1:LO_W] <= shreg[HI_W:1];
                            rw                  <= shreg[0];
                        end
                        if (state == ST_WADDR) addr[LO_W-1:0] <= shreg[LO_W-1:0];
                        if (state == ST_WDATA)
                            addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                    end
                end
                ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) cnt <= '0;
                end
                ST_RD_LOAD: begin
                    shreg <= mem_rdata;
                    cnt   <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg <= {shreg[DATA_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise && !sda_s) addr <= addr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        mem_we = 1'b0;
        mem_re = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:    sda_oe = ~shreg[DATA_W-1];
            ST_RD_FETCH: mem_re = 1'b1;
            ST_WDATA:    mem_we = scl_fall && full && !start_det && !stop_det;
            default: ;
        endcase
    end

    assign mem_addr  = addr;
    assign mem_wdata = shreg;
endmodule

// File: rtl/twm_checker.sv
module twm_checker
    import twm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input twm_state_e state,
    input logic       start_det,
    input logic       stop_det,
    input logic       busy_i,
    input logic       sda_oe,
    input logic       mem_we,
    input logic       mem_re
);
    p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));

    p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK && $past(state) == ST_DEV) |-> !$past(busy_i));

    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_no_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_re_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
endmodule

bind twowire_mem_slave twm_checker chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .start_det(start_det),
    .stop_det(stop_det), .busy_i(busy_i), .sda_oe(sda_oe),
    .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/twowire_mem_slave_tb_top.sv
module twowire_mem_slave_tb_top;
    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1, sda_m = 1'b1;
    logic [2:0]  sel = 3'b000;
    logic        busy = 1'b0;
    logic        sda_oe, mem_we, mem_re;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        sda_bus;
    logic [7:0]  mem [2048];
    int          n_tests = 0, n_fail = 0, we_cnt = 0;
    logic        mon_en = 1'b0, oe_seen = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    twowire_mem_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .sel_i(sel), .busy_i(busy), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pre(input int a);
        return 8'((a * 13) + (a >> 8) * 91 + 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= pre(i);
            mem_rdata <= '0;
        end else begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (mem_re) mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk) if (mon_en && sda_oe) oe_seen <= 1'b1;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q / 2);
        ack = ~sda_bus;
        tick(Q / 2);
        scl = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q / 2);
            d = {d[6:0], sda_bus};
            tick(Q / 2);
            scl = 1'b0;
        end
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0;
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic [2:0] hi, input logic r);
        return {1'b1, s[2], ~s[1], s[0], hi, r};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         w0;
        tick(3);
        // R9: quiet during reset
        check(!sda_oe && !mem_we && !mem_re, "R9 reset", {sda_oe, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        tick(5);

        // R2: sweep upper nibble of the slave byte, pins 101 -> only 4'hF matches
        sel = 3'b101;
        for (int n = 0; n < 16; n++) begin
            bus_start();
            send_byte({4'(n), 4'b0000}, ack);
            bus_stop();
            check(ack == (n == 15), "R2 nibble sweep", ack, (n == 15));
        end
        // R2: every pin setting, S1 inverted acks, S1 direct does not
        for (int p = 0; p < 8; p++) begin
            sel = 3'(p);
            bus_start();
            send_byte({1'b1, sel[2], ~sel[1], sel[0], 4'b0000}, ack);
            bus_stop();
            check(ack, "R2 pin sweep inverted S1", ack, 1);
            bus_start();
            send_byte({1'b1, sel[2], sel[1], sel[0], 4'b0000}, ack);
            bus_stop();
            check(!ack, "R2 pin sweep direct S1", ack, 0);
        end

        sel = 3'b010;
        // R4: byte write at {5, 42h}
        w0 = we_cnt;
        bus_start();
        send_byte(dev_byte(sel, 3'd5, 1'b0), ack);
        check(ack, "R4 slave ack", ack, 1);
        send_byte(8'h42, ack);
        check(ack, "R4 word addr ack", ack, 1);
        send_byte(8'hA7, ack);
        check(ack, "R4 data ack", ack, 1);
        bus_stop();
        tick(4);
        check(mem[11'h542] == 8'hA7, "R4 byte write", mem[11'h542], 8'hA7);
        check(we_cnt - w0 == 1, "R4 one write", we_cnt - w0, 1);

        // R5: page write across 1Fh, wraps to 00h in the page
        bus_start();
        send_byte(dev_byte(sel, 3'd2, 1'b0), ack);
        send_byte(8'h1E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        bus_stop();
        tick(4);
        check(mem[11'h21E] == 8'h11, "R5 page byte0", mem[11'h21E], 8'h11);
        check(mem[11'h21F] == 8'h22, "R5 page byte1", mem[11'h21F], 8'h22);
        check(mem[11'h200] == 8'h33, "R5 page wrap", mem[11'h200], 8'h33);
        check(mem[11'h220] == pre(11'h220), "R5 next page untouched", mem[11'h220], pre(11'h220));

        // R6, R7: random read at 542h, then sequential
        bus_start();
        send_byte(dev_byte(sel, 3'd5, 1'b0), ack);
        send_byte(8'h42, ack);
        bus_start();
        send_byte(dev_byte(sel, 3'd5, 1'b1), ack);
        check(ack, "R6 read slave ack", ack, 1);
        read_byte(1'b1, d);
        check(d == 8'hA7, "R6 read data", d, 8'hA7);
        read_byte(1'b0, d);
        check(d == pre(11'h543), "R7 sequential read", d, pre(11'h543));
        bus_stop();

        // R6: high bits taken from the read slave byte, low bits retained
        bus_start();
        send_byte(dev_byte(sel, 3'd0, 1'b0), ack);
        send_byte(8'h10, ack);
        bus_start();
        send_byte(dev_byte(sel, 3'd6, 1'b1), ack);
        read_byte(1'b0, d);
        check(d == pre(11'h610), "R6 high bits from read byte", d, pre(11'h610));
        bus_stop();

        // R7: wrap 7FFh -> 000h -> 001h; R8: no drive after nack
        bus_start();
        send_byte(dev_byte(sel, 3'd7, 1'b0), ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(dev_byte(sel, 3'd7, 1'b1), ack);
        read_byte(1'b1, d);
        check(d == pre(11'h7FF), "R7 read 7FF", d, pre(11'h7FF));
        read_byte(1'b1, d);
        check(d == pre(0), "R7 wrap to 000", d, pre(0));
        read_byte(1'b0, d);
        check(d == pre(1), "R7 after wrap", d, pre(1));
        oe_seen = 1'b0;
        mon_en = 1'b1;
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        mon_en = 1'b0;
        check(!oe_seen, "R8 released after nack", oe_seen, 0);
        bus_stop();

        // R3: busy refuses address and issues no write
        busy = 1'b1;
        w0 = we_cnt;
        bus_start();
        send_byte(dev_byte(sel, 3'd3, 1'b0), ack);
        check(!ack, "R3 no ack while busy", ack, 0);
        send_byte(8'h00, ack);
        send_byte(8'h99, ack);
        bus_stop();
        tick(4);
        check(we_cnt == w0, "R3 no write while busy", we_cnt - w0, 0);
        busy = 1'b0;
        bus_start();
        send_byte(dev_byte(sel, 3'd3, 1'b0), ack);
        bus_stop();
        check(ack, "R3 ack once idle", ack, 1);

        // R1: restart in the middle of a word address aborts it
        w0 = we_cnt;
        bus_start();
        send_byte(dev_byte(sel, 3'd1, 1'b0), ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(dev_byte(sel, 3'd1, 1'b0), ack);
        check(ack, "R1 restart slave ack", ack, 1);
        send_byte(8'h33, ack);
        send_byte(8'h5C, ack);
        bus_stop();
        tick(4);
        check(mem[11'h133] == 8'h5C, "R1 restart write", mem[11'h133], 8'h5C);
        check(we_cnt - w0 == 1, "R1 single write after abort", we_cnt - w0, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule